// File: doc/BRIEF.md
# Lane-Sliced Single-Error-Correcting Memory

This block is a synchronous single-port memory that keeps every stored word protected by Hamming check bits. It does not use one wide code over the whole word. Instead it cuts the data word into 9-bit lanes and gives each lane its own 4-bit check code. The check bits go into a parity array of their own, beside the data array, and they never appear at the host interface. The host sees only data bits.

On a read, the data and check bits of every lane pass through a lane decoder. A single flipped bit in a lane is inverted back before the word leaves the block. Each lane can repair one bit independently of the others. Errors of two or more bits inside one lane are neither flagged as such nor repaired, and the word is delivered as the decoder leaves it. A debug injection port can XOR masks into the stored data or check bits of one address. This lets a testbench create single-bit and multi-bit faults.

Top module: `hsec_mem`

## Requirements
- R1: The data width `DW` is a parameter that must be a multiple of nine, and elaboration rejects any other value. Lane k covers data bits `9k+8:9k`. There are `DW/9` lanes, and each lane has four check bits held in a parity array that no port reads or writes.
- R2: A read of an address returns exactly the word last written there, with all lane flags low, when no fault was injected into that address since the write.
- R3: `rvalid` is high exactly in the cycle after a request with `req`=1 and `we`=0, and it is low in every other cycle, including after writes. `rdata` and `lane_fix` change only on a read and otherwise hold their values.
- R4: In each lane, codeword positions 1, 2, 4 and 8 carry check bits 0 to 3. Data bit j of the lane (j = 0..8) sits at the j-th remaining position in rising order: 3, 5, 6, 7, 9, 10, 11, 12, 13. Check bit i is the XOR of the data bits whose position has bit i set. The lane syndrome is the stored check bits XOR the recomputed check bits.
- R5: One flipped data bit in a lane is corrected at `rdata`, and that lane's `lane_fix` bit is high.
- R6: One flipped bit in every lane of the same word is fully corrected, and every `lane_fix` bit is high.
- R7: A flipped check bit leaves the data output equal to the stored data, and the lane flag is high.
- R8: For two or more flipped bits in a lane, the data bit at the syndrome position (if that position is a data position) is inverted and the other errors pass through. The lane flag is high exactly when the syndrome lies in 1..13. Syndromes 14 and 15 leave the data bits as stored.
- R9: When `inj_en`=1, the stored data of `inj_addr` is XORed with `inj_dmask`, and its check bits are XORed with `inj_cmask` (lane k check bit i at bit `4k+i`). If a write to the same address happens in the same cycle, the mask is applied on top of the newly written word.
- R10: While reset is asserted and after it, until the first read, `rvalid`, `rdata` and `lane_fix` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read, qualified by `req` |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Corrected read data |
| rvalid | output | 1 | Read data valid, one cycle after the read request |
| lane_fix | output | DW/9 | Per-lane flag: the syndrome pointed at a codeword position |
| inj_en | input | 1 | Apply fault masks this cycle |
| inj_addr | input | AW | Address to corrupt |
| inj_dmask | input | DW | XOR mask for the stored data bits |
| inj_cmask | input | 4*DW/9 | XOR mask for the stored check bits |

## Verification
The hardest situations to reach are the multi-bit lane faults. These are the cases where the syndrome points at a different data bit, at a check position, or at the invalid values 14 and 15. Normal writes always store a consistent codeword, so the host interface alone never reaches them. The bench uses the injection port to flip chosen pairs of bits, with directed pairs picked to hit each syndrome class. Random one-bit and two-bit masks then spread the faults over lanes and addresses. A bench model of the code predicts the exact delivered data and flags for each case.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
   localparam int LANE_W = 9;
   localparam int CHK_W  = 4;
   localparam int CODE_W = 13;

   // position (1..13) of lane data bit j: the non-power-of-two slots in order
   function automatic int data_pos(input int j);
      int n;
      int found;
      n     = 0;
      found = 0;
      for (int p = 1; p <= CODE_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == j) found = p;
            n++;
         end
      end
      return found;
   endfunction

   function automatic logic [CHK_W-1:0] lane_check(input logic [LANE_W-1:0] d);
      logic [CHK_W-1:0] c;
      int pos;
      c = '0;
      for (int j = 0; j < LANE_W; j++) begin
         pos = data_pos(j);
         for (int k = 0; k < CHK_W; k++)
            if (((pos >> k) & 1) == 1) c[k] = c[k] ^ d[j];
      end
      return c;
   endfunction
endpackage

// File: rtl/hsec_lane_enc.sv
module hsec_lane_enc
   import hsec_pkg::*;
(
   input  logic [LANE_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);
   always_comb chk = lane_check(data);
endmodule

// File: rtl/hsec_lane_dec.sv
module hsec_lane_dec
   import hsec_pkg::*;
(
   input  logic [LANE_W-1:0] data,
   input  logic [CHK_W-1:0]  chk,
   output logic [LANE_W-1:0] fixed,
   output logic              hit
);
   logic [CHK_W-1:0] syn;

   always_comb begin
      syn = chk ^ lane_check(data);
      hit = (syn != '0) && (syn <= 4'(CODE_W));
      for (int j = 0; j < LANE_W; j++)
         fixed[j] = data[j] ^ (syn == 4'(data_pos(j)));
   end
endmodule

// File: rtl/hsec_store.sv
module hsec_store #(
   parameter int DW    = 36,
   parameter int CW    = 16,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   input  logic [CW-1:0] wr_chk,
   input  logic          inj_en,
   input  logic [AW-1:0] inj_addr,
   input  logic [DW-1:0] inj_dmask,
   input  logic [CW-1:0] inj_cmask,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] rd_chk
);
   logic [DW-1:0] data_arr [DEPTH];
   logic [CW-1:0] chk_arr  [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (wr_en && addr == AW'(i)) begin
            data_arr[i] <= wr_data ^ ((inj_en && inj_addr == AW'(i)) ? inj_dmask : '0);
            chk_arr[i]  <= wr_chk  ^ ((inj_en && inj_addr == AW'(i)) ? inj_cmask : '0);
         end else if (inj_en && inj_addr == AW'(i)) begin
            data_arr[i] <= data_arr[i] ^ inj_dmask;
            chk_arr[i]  <= chk_arr[i]  ^ inj_cmask;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_chk  <= '0;
      end else if (rd_en) begin
         rd_data <= data_arr[addr];
         rd_chk  <= chk_arr[addr];
      end
   end
endmodule

// File: rtl/hsec_mem.sv
module hsec_mem
   import hsec_pkg::*;
#(
   parameter int DW    = 36,
   parameter int DEPTH = 64,
   localparam int LANES = DW / LANE_W,
   localparam int CW    = LANES * CHK_W,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rvalid,
   output logic [LANES-1:0] lane_fix,
   input  logic             inj_en,
   input  logic [AW-1:0]    inj_addr,
   input  logic [DW-1:0]    inj_dmask,
   input  logic [CW-1:0]    inj_cmask
);
   generate
      if ((DW % LANE_W) != 0 || DW < LANE_W) begin : g_bad_width
         $error("hsec_mem: DW must be a positive multiple of nine");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("hsec_mem: DEPTH must be at least two");
      end
   endgenerate

   logic             wr_en, rd_en;
   logic [CW-1:0]    wr_chk, rd_chk;
   logic [DW-1:0]    rd_raw;
   logic [LANES-1:0] lane_hit;

   assign wr_en = req & we;
   assign rd_en = req & ~we;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      hsec_lane_enc u_enc (
         .data (wdata[k*LANE_W +: LANE_W]),
         .chk  (wr_chk[k*CHK_W +: CHK_W])
      );
      hsec_lane_dec u_dec (
         .data  (rd_raw[k*LANE_W +: LANE_W]),
         .chk   (rd_chk[k*CHK_W +: CHK_W]),
         .fixed (rdata[k*LANE_W +: LANE_W]),
         .hit   (lane_hit[k])
      );
   end

   hsec_store #(.DW(DW), .CW(CW), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wr_data   (wdata),
      .wr_chk    (wr_chk),
      .inj_en    (inj_en),
      .inj_addr  (inj_addr),
      .inj_dmask (inj_dmask),
      .inj_cmask (inj_cmask),
      .rd_data   (rd_raw),
      .rd_chk    (rd_chk)
   );

   logic [LANES-1:0] fix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_en;
      end
   end

   // flags follow the held read word; decoded combinationally after the register
   always_comb fix_q = lane_hit;
   assign lane_fix = fix_q;
endmodule

// File: rtl/hsec_mem_chk.sv
module hsec_mem_chk #(
   parameter int DW    = 36,
   parameter int DEPTH = 64,
   localparam int LANES = DW / 9,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic             we,
   input logic [DW-1:0]    rdata,
   input logic             rvalid,
   input logic [LANES-1:0] lane_fix
);
   AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we) |=> rvalid); // R3

   AST_NO_VALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && !we) |=> !rvalid); // R3

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && !we) |=> $stable(rdata)); // R3

   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && !we) |=> $stable(lane_fix)); // R3
endmodule

bind hsec_mem hsec_mem_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .we       (we),
   .rdata    (rdata),
   .rvalid   (rvalid),
   .lane_fix (lane_fix)
);

// File: tb/sim_hsec_mem.sv
`timescale 1ns/1ps
module sim_hsec_mem;
   localparam int DW    = 36;
   localparam int DEPTH = 64;
   localparam int LANES = DW / 9;
   localparam int CW    = LANES * 4;
   localparam int AW    = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, we = 1'b0, inj_en = 1'b0;
   logic [AW-1:0] addr = '0, inj_addr = '0;
   logic [DW-1:0] wdata = '0, inj_dmask = '0;
   logic [CW-1:0] inj_cmask = '0;
   logic [DW-1:0] rdata;
   logic rvalid;
   logic [LANES-1:0] lane_fix;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [DW-1:0] m_d [DEPTH];
   logic [CW-1:0] m_c [DEPTH];

   always #10 clk = ~clk;

   hsec_mem #(.DW(DW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid), .lane_fix(lane_fix), .inj_en(inj_en),
      .inj_addr(inj_addr), .inj_dmask(inj_dmask), .inj_cmask(inj_cmask)
   );

   // R4 layout: data bit j at the j-th non-power-of-two position of 1..13
   function automatic int b_pos(input int j);
      int p;
      int n;
      n = -1;
      p = 0;
      while (n < j) begin
         p++;
         if ((p & (p - 1)) != 0) n++;
      end
      return p;
   endfunction

   function automatic logic [3:0] b_chk(input logic [8:0] d);
      logic [3:0] c;
      c = '0;
      for (int j = 0; j < 9; j++)
         for (int i = 0; i < 4; i++)
            if (b_pos(j) & (1 << i)) c[i] ^= d[j];
      return c;
   endfunction

   function automatic logic [DW-1:0] exp_data(input int a);
      logic [DW-1:0] r;
      logic [3:0] s;
      r = m_d[a];
      for (int k = 0; k < LANES; k++) begin
         s = m_c[a][4*k +: 4] ^ b_chk(m_d[a][9*k +: 9]);
         for (int j = 0; j < 9; j++)
            if (int'(s) == b_pos(j)) r[9*k + j] = ~r[9*k + j];
      end
      return r;
   endfunction

   function automatic logic [LANES-1:0] exp_flag(input int a);
      logic [LANES-1:0] f;
      logic [3:0] s;
      for (int k = 0; k < LANES; k++) begin
         s = m_c[a][4*k +: 4] ^ b_chk(m_d[a][9*k +: 9]);
         f[k] = (s != 0) && (s <= 13);
      end
      return f;
   endfunction

   function automatic logic [DW-1:0] rnd_word();
      return DW'({$urandom(), $urandom()});
   endfunction

   task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      req = 1; we = 1; addr = AW'(a); wdata = d;
      @(negedge clk);
      req = 0; we = 0;
      for (int k = 0; k < LANES; k++) m_c[a][4*k +: 4] = b_chk(d[9*k +: 9]);
      m_d[a] = d;
      check(rvalid == 1'b0, "R3 write no valid", 64'(rvalid), 64'd0);
   endtask

   task automatic do_inject(input int a, input logic [DW-1:0] dm, input logic [CW-1:0] cm);
      @(negedge clk);
      inj_en = 1; inj_addr = AW'(a); inj_dmask = dm; inj_cmask = cm;
      @(negedge clk);
      inj_en = 0; inj_dmask = '0; inj_cmask = '0;
      m_d[a] ^= dm;
      m_c[a] ^= cm;
   endtask

   task automatic do_read(input int a, input string rq);
      @(negedge clk);
      req = 1; we = 0; addr = AW'(a);
      @(negedge clk);
      req = 0;
      check(rvalid == 1'b1, rq, 64'(rvalid), 64'd1);
      check(rdata == exp_data(a), rq, 64'(rdata), 64'(exp_data(a)));
      check(lane_fix == exp_flag(a), rq, 64'(lane_fix), 64'(exp_flag(a)));
   endtask

   // one-bit mask at lane k, lane data bit j
   function automatic logic [DW-1:0] dbit(input int k, input int j);
      return DW'(1) << (9*k + j);
   endfunction

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] held_d;
      logic [LANES-1:0] held_f;
      logic [DW-1:0] w;
      void'($urandom(32'd24680));
      repeat (3) @(negedge clk);
      // R10 reset state
      check(rvalid == 0 && rdata == '0 && lane_fix == '0, "R10 in reset",
            64'({rvalid, lane_fix, rdata}), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check(rvalid == 0 && rdata == '0 && lane_fix == '0, "R10 after reset",
            64'({rvalid, lane_fix, rdata}), 64'd0);

      for (int a = 0; a < DEPTH; a++) do_write(a, rnd_word());
      // R2 clean read-back
      do_read(0, "R2 clean read");
      do_read(DEPTH - 1, "R2 clean read top");
      do_write(5, '1);
      do_read(5, "R2 all ones");

      // R3 hold between reads
      held_d = rdata; held_f = lane_fix;
      do_write(6, '0);
      @(negedge clk);
      check(rvalid == 0, "R3 idle no valid", 64'(rvalid), 64'd0);
      check(rdata == held_d && lane_fix == held_f, "R3 hold", 64'(rdata), 64'(held_d));

      // R5 single data-bit error in lane 1 bit 4
      do_inject(10, dbit(1, 4), '0);
      do_read(10, "R5 single data bit");
      // R6 single error in every lane
      w = '0;
      for (int k = 0; k < LANES; k++) w |= dbit(k, (k * 2) % 9);
      do_inject(11, w, '0);
      do_read(11, "R6 every lane");
      check(lane_fix == '1, "R6 all flags", 64'(lane_fix), 64'(LANES'('1)));
      // R7 check-bit error: lane 2 check bit 3
      do_inject(12, '0, CW'(1) << (4*2 + 3));
      do_read(12, "R7 check bit");
      check(rdata == m_d[12], "R7 data intact", 64'(rdata), 64'(m_d[12]));
      // R8 positions 3 and 13 -> syndrome 14, no flag, both errors pass
      do_inject(13, dbit(0, 0) | dbit(0, 8), '0);
      do_read(13, "R8 syndrome 14");
      check(lane_fix[0] == 0, "R8 no flag on 14", 64'(lane_fix), 64'd0);
      // R8 positions 3 and 5 -> syndrome 6 -> data bit 2 miscorrected
      do_inject(14, dbit(3, 0) | dbit(3, 1), '0);
      do_read(14, "R8 miscorrect");
      // R8 positions 3 and 7 -> syndrome 4 (check slot)
      do_inject(15, dbit(1, 0) | dbit(1, 3), '0);
      do_read(15, "R8 syndrome at check slot");
      // R9 inject coinciding with write to the same address
      @(negedge clk);
      w = rnd_word();
      req = 1; we = 1; addr = AW'(20); wdata = w;
      inj_en = 1; inj_addr = AW'(20); inj_dmask = dbit(2, 7); inj_cmask = '0;
      @(negedge clk);
      req = 0; we = 0; inj_en = 0; inj_dmask = '0;
      m_d[20] = w ^ dbit(2, 7);
      for (int k = 0; k < LANES; k++) m_c[20][4*k +: 4] = b_chk(w[9*k +: 9]);
      do_read(20, "R9 write plus inject");
      check(rdata == w, "R9 corrected to written", 64'(rdata), 64'(w));
      // R1 lane boundary: top bit of last lane
      do_inject(21, dbit(LANES - 1, 8), '0);
      do_read(21, "R1 top lane bit");

      // random mix
      for (int n = 0; n < 600; n++) begin
         int a;
         int op;
         a  = int'($urandom_range(DEPTH - 1));
         op = int'($urandom_range(9));
         if (op < 3) do_write(a, rnd_word());
         else if (op < 5) begin
            int k;
            k = int'($urandom_range(LANES - 1));
            if ($urandom_range(1) == 0)
               do_inject(a, dbit(k, int'($urandom_range(8))), '0);
            else
               do_inject(a, dbit(k, int'($urandom_range(8))) | dbit(k, int'($urandom_range(8))),
                         CW'($urandom_range(1)) << (4*k + int'($urandom_range(3))));
         end
         else do_read(a, "R8 random read");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule